// File: doc/BRIEF.md
# SPI Bidirectional Data Shift Register

This block is the data register of an SPI engine. A single register of `WIDTH` bits serialises outgoing data and deserialises incoming data in the same transfer. Bits leave at one end of the register and enter at the other. A run-time order select decides which end is which. The register keeps shifting through the write part of a transfer and through the read part. Two one-cycle strobes drive it, and both come from an external clock generator. The sample strobe captures the serial input into a holding bit. The shift strobe moves the register by one place and inserts that held bit.

Software fills the register through a valid/ready load port while no transfer is running. After the transfer it reads the contents in parallel. A load is accepted only on a cycle where `load_valid` and `load_ready` are both high. `load_ready` is low while `xfer_active` is high, so the producer must hold its word until the transfer ends. The control pins and the strobes are plain signals with no handshake.

Top module: `spi_shift_reg`

## Requirements
- R1: After reset, `data_q` is all zeros, the holding bit is zero, `sdo` is 0 and `load_ready` is 1 while `xfer_active` is low.
- R2: While `xfer_active` is low, `load_ready` is 1. A cycle with `load_valid` high replaces the whole of `data_q` with `load_data` from the next cycle on.
- R3: While `xfer_active` is high, `load_ready` is 0 and `load_valid` has no effect on `data_q`.
- R4: With `lsb_first` = 0, `sdo` equals bit WIDTH-1 (the MSB) of `data_q`. The first bit sent is therefore the MSB, whatever the number of bits that follow.
- R5: With `lsb_first` = 1, `sdo` equals bit 0 (the LSB) of `data_q`.
- R6: A `sample_stb` cycle during a transfer latches `sdi` into the holding bit. A `shift_stb` cycle during a transfer shifts `data_q` by one place. With `lsb_first` = 0 it shifts towards the MSB and the held bit enters bit 0. With `lsb_first` = 1 it shifts towards the LSB and the held bit enters bit WIDTH-1. The last bit received therefore lands in the LSB for MSB-first order and in the MSB for LSB-first order.
- R7: When `sdo` is looped back to `sdi` and a transfer runs N sample-then-shift bit cycles, the result depends only on N, not on how N is split into write and read bits. The final `data_q` is the loaded word rotated left by N for `lsb_first` = 0 and rotated right by N for `lsb_first` = 1. N = WIDTH gives back the loaded word.
- R8: `shift_stb` and `sample_stb` have no effect while `xfer_active` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lsb_first | input | 1 | 0: MSB leaves first, 1: LSB leaves first |
| xfer_active | input | 1 | High while a transfer is running |
| load_valid | input | 1 | Parallel load word offered |
| load_ready | output | 1 | Load can be accepted (no transfer running) |
| load_data | input | WIDTH | Parallel load word |
| shift_stb | input | 1 | One-cycle shift-out strobe |
| sample_stb | input | 1 | One-cycle sample-in strobe |
| sdi | input | 1 | Serial input bit |
| sdo | output | 1 | Serial output bit |
| data_q | output | WIDTH | Parallel register contents |

## Verification
An accepted load appears on `data_q` one cycle after the accepting edge. `sdo` follows `data_q` with no added register. A sampled bit sits in the holding bit until the next shift edge, and its effect on `data_q` is visible one cycle after the shift strobe. The bench drives every input on the falling edge. It reads results at the falling edge that follows the edge where they are due, so each comparison falls exactly one register stage after its stimulus. The loopback sweeps cover both bit orders, several patterns and lengths 1, 8 and 32, and their expected values come from arithmetic rotations.

// File: rtl/spi_sr_pkg.sv
package spi_sr_pkg;
  typedef enum logic {
    ORDER_MSB = 1'b0,
    ORDER_LSB = 1'b1
  } bit_order_e;
endpackage

// File: rtl/spi_sr_sample.sv
module spi_sr_sample (
  input  logic clk,
  input  logic rst_n,
  input  logic sample_en,
  input  logic sdi,
  output logic hold
);
  always_ff @(posedge clk) begin
    if (!rst_n)         hold <= 1'b0;
    else if (sample_en) hold <= sdi;
  end

  assert_sample_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sample_en |=> hold == $past(sdi));
  assert_hold_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_en |=> $stable(hold));
endmodule

// File: rtl/spi_sr_load.sv
module spi_sr_load (
  input  logic xfer_active,
  input  logic load_valid,
  output logic load_ready,
  output logic load_fire
);
  assign load_ready = ~xfer_active;
  assign load_fire  = load_valid & load_ready;
endmodule

// File: rtl/spi_sr_core.sv
module spi_sr_core
  import spi_sr_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  bit_order_e       order,
  input  logic             load_en,
  input  logic [WIDTH-1:0] load_data,
  input  logic             shift_en,
  input  logic             shift_in,
  output logic [WIDTH-1:0] data_q,
  output logic             sdo
);
  localparam int TOP = WIDTH - 1;

  logic [WIDTH-1:0] shreg;
  logic [WIDTH-1:0] shifted;

  // Per-bit neighbour selection: each bit takes from the lower or the upper
  // neighbour depending on the order; the end bits take the held input.
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic from_lo;
    logic from_hi;
    if (i == 0) begin : g_lo_end
      assign from_lo = shift_in;
    end else begin : g_lo_mid
      assign from_lo = shreg[i-1];
    end
    if (i == TOP) begin : g_hi_end
      assign from_hi = shift_in;
    end else begin : g_hi_mid
      assign from_hi = shreg[i+1];
    end
    assign shifted[i] = (order == ORDER_LSB) ? from_hi : from_lo;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        shreg <= '0;
    else if (load_en)  shreg <= load_data;
    else if (shift_en) shreg <= shifted;
  end

  assign data_q = shreg;
  assign sdo    = (order == ORDER_LSB) ? shreg[0] : shreg[TOP];

  assert_load_applies_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> data_q == $past(load_data));
  assert_idle_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && !shift_en) |=> $stable(data_q));
  assert_msb_order_shift_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !load_en && order == ORDER_MSB) |=>
      (data_q[TOP:1] == $past(data_q[TOP-1:0])) && (data_q[0] == $past(shift_in)));
  assert_lsb_order_shift_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !load_en && order == ORDER_LSB) |=>
      (data_q[TOP-1:0] == $past(data_q[TOP:1])) && (data_q[TOP] == $past(shift_in)));
endmodule

// File: rtl/spi_shift_reg.sv
module spi_shift_reg
  import spi_sr_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lsb_first,
  input  logic             xfer_active,
  input  logic             load_valid,
  output logic             load_ready,
  input  logic [WIDTH-1:0] load_data,
  input  logic             shift_stb,
  input  logic             sample_stb,
  input  logic             sdi,
  output logic             sdo,
  output logic [WIDTH-1:0] data_q
);
  bit_order_e order;
  logic       load_fire;
  logic       shift_en;
  logic       sample_en;
  logic       hold;

  assign order     = lsb_first ? ORDER_LSB : ORDER_MSB;
  assign shift_en  = shift_stb & xfer_active;
  assign sample_en = sample_stb & xfer_active;

  spi_sr_load u_load (
    .xfer_active (xfer_active),
    .load_valid  (load_valid),
    .load_ready  (load_ready),
    .load_fire   (load_fire)
  );

  spi_sr_sample u_sample (
    .clk       (clk),
    .rst_n     (rst_n),
    .sample_en (sample_en),
    .sdi       (sdi),
    .hold      (hold)
  );

  spi_sr_core #(.WIDTH(WIDTH)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .order     (order),
    .load_en   (load_fire),
    .load_data (load_data),
    .shift_en  (shift_en),
    .shift_in  (hold),
    .data_q    (data_q),
    .sdo       (sdo)
  );

  assert_busy_blocks_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_active && !shift_stb) |=> $stable(data_q));
  assert_strobes_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer_active && !load_valid) |=> $stable(data_q));
endmodule

// File: tb/tb_spi_shift_reg.sv
module tb_spi_shift_reg;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        lsb_first, xfer_active, load_valid, load_ready;
  logic [31:0] load_data, data_q;
  logic        shift_stb, sample_stb, sdi, sdo;
  logic        loop_en, ext_bit;
  int          checks = 0;
  int          fails = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;
  assign sdi = loop_en ? sdo : ext_bit;

  spi_shift_reg dut (
    .clk(clk), .rst_n(rst_n), .lsb_first(lsb_first), .xfer_active(xfer_active),
    .load_valid(load_valid), .load_ready(load_ready), .load_data(load_data),
    .shift_stb(shift_stb), .sample_stb(sample_stb), .sdi(sdi), .sdo(sdo),
    .data_q(data_q)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rotl(input logic [31:0] v, input int n);
    return (n % 32 == 0) ? v : ((v << n) | (v >> (32 - n)));
  endfunction
  function automatic logic [31:0] rotr(input logic [31:0] v, input int n);
    return (n % 32 == 0) ? v : ((v >> n) | (v << (32 - n)));
  endfunction

  task automatic do_load(input logic [31:0] v);
    @(negedge clk);
    chk("R2 load_ready idle", {31'd0, load_ready}, 32'd1);
    load_valid = 1'b1; load_data = v;
    @(negedge clk);
    load_valid = 1'b0;
    chk("R2 load contents", data_q, v);
  endtask

  // n bit cycles: sample, then shift. External bits: msb order sends
  // stream[n-1] first, lsb order sends stream[0] first.
  task automatic run_bits(input int n, input logic [31:0] stream);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      ext_bit = lsb_first ? stream[k] : stream[n-1-k];
      sample_stb = 1'b1;
      @(negedge clk);
      sample_stb = 1'b0; shift_stb = 1'b1;
      @(negedge clk);
      shift_stb = 1'b0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] pats [3];
    int          lens [3];
    pats[0] = 32'hA5C3_0F1E; pats[1] = 32'h8000_0001; pats[2] = 32'h1234_5678;
    lens[0] = 1; lens[1] = 8; lens[2] = 32;
    rst_n = 1'b0; lsb_first = 1'b0; xfer_active = 1'b0; load_valid = 1'b0;
    load_data = '0; shift_stb = 1'b0; sample_stb = 1'b0; loop_en = 1'b1; ext_bit = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 data_q reset", data_q, 32'd0);
    chk("R1 sdo reset", {31'd0, sdo}, 32'd0);
    chk("R1 load_ready reset", {31'd0, load_ready}, 32'd1);

    // R7 loopback sweep, both orders; R4/R5 first bit
    for (int o = 0; o < 2; o++) begin
      for (int li = 0; li < 3; li++) begin
        for (int pi = 0; pi < 3; pi++) begin
          lsb_first = o[0];
          do_load(pats[pi]);
          if (o == 0) chk("R4 first bit msb", {31'd0, sdo}, {31'd0, pats[pi][31]});
          else        chk("R5 first bit lsb", {31'd0, sdo}, {31'd0, pats[pi][0]});
          xfer_active = 1'b1;
          run_bits(lens[li], 32'd0);
          xfer_active = 1'b0;
          chk("R7 loopback rotation", data_q,
              (o == 0) ? rotl(pats[pi], lens[li]) : rotr(pats[pi], lens[li]));
        end
      end
    end

    // R6 external input, msb order: last bit received lands in LSB
    loop_en = 1'b0; lsb_first = 1'b0;
    do_load(32'hDEAD_BEEF);
    xfer_active = 1'b1;
    run_bits(8, 32'h0000_0096);
    xfer_active = 1'b0;
    chk("R6 msb-first receive", data_q, 32'hADBE_EF96);

    // R6 external input, lsb order: last bit received lands in MSB
    lsb_first = 1'b1;
    do_load(32'hDEAD_BEEF);
    xfer_active = 1'b1;
    run_bits(8, 32'h0000_0069);
    xfer_active = 1'b0;
    chk("R6 lsb-first receive", data_q, 32'h69DE_ADBE);

    // R3 load blocked during transfer
    do_load(32'h0BAD_F00D);
    xfer_active = 1'b1;
    @(negedge clk);
    chk("R3 load_ready busy", {31'd0, load_ready}, 32'd0);
    load_valid = 1'b1; load_data = 32'hFFFF_FFFF;
    @(negedge clk);
    load_valid = 1'b0;
    chk("R3 busy load ignored", data_q, 32'h0BAD_F00D);
    xfer_active = 1'b0;

    // R8 strobes ignored while idle
    ext_bit = 1'b1;
    @(negedge clk);
    sample_stb = 1'b1;
    @(negedge clk);
    sample_stb = 1'b0; shift_stb = 1'b1;
    @(negedge clk);
    shift_stb = 1'b0;
    chk("R8 idle strobes ignored", data_q, 32'h0BAD_F00D);
    // held bit must still be zero-free of the idle sample: shift once in a transfer
    xfer_active = 1'b1; ext_bit = 1'b0;
    @(negedge clk);
    shift_stb = 1'b1;
    @(negedge clk);
    shift_stb = 1'b0; xfer_active = 1'b0;
    chk("R8 idle sample not held", data_q, 32'h05D6_F806);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule